// File: doc/BRIEF.md
# Indirect Interrupt Routing Register File

This block holds the programmable state of an I/O interrupt router and presents it to software through two bus locations only: a select register and a data window. Software writes a register number into the select register, then reads or writes the window to reach the register that number names. Behind the window sit an identification register, a read-only version word, an arbitration word that mirrors the identification field, and a table of 64-bit routing entries, one per interrupt pin. Each entry is reached as two 32-bit halves through two consecutive window numbers.

The whole routing table is driven out in parallel to the delivery logic, which owns edge and level sensing, the in-service handshake and message generation. The delivery logic sets an entry's in-service (remote-IRR) flag through a per-pin set input. The block clears that flag whenever software rewrites the low half of the entry, and it reports the clear on a per-pin strobe. It also emits a per-entry write pulse and a single-cycle mask-change event that carries the pin number and the new mask value.

The bus port is a simple one-beat request/response port. It carries the low byte of the access address (the fabric decodes the upper address bits), a byte length and the low 32-bit word of the write data. Read data returns one cycle after the request.

Top module: `intr_route_regfile`

## Requirements
- R1: A write of 4 or 8 bytes to offset 0x00 loads the 32-bit select register. A read of offset 0x00 returns it.
- R2: With select = 1, a window read returns (NUM_PINS − 1) in bits 23:16 and VERSION_CODE in bits 7:0, with all other bits zero. Window writes at select = 1 change nothing.
- R3: With select = 0, a window write stores data bits 27:24 as the 4-bit ID, and a window read returns the ID in bits 27:24 with all other bits zero. With select = 2, a window read returns the same value and a window write changes nothing.
- R4: With select ≥ 0x10, the window reaches entry index (select − 0x10) >> 1. An even select reaches entry bits 31:0 and an odd select reaches bits 63:32. Entry layout: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-IRR 14, trigger mode 15 (1 = level), mask 16, destination 63:56.
- R5: A window write to the low half of an entry forces its remote-IRR bit (bit 14) to 0, whatever the data holds, and this wins over a set in the same cycle. A high-half write leaves bit 14 unchanged. A rirr_set_i pulse sets bit 14 of that entry.
- R6: When select is 3..0x0F, or its computed index is ≥ NUM_PINS, window writes change no register and window reads return 0.
- R7: Only 4-byte and 8-byte writes take effect, and only the 32-bit word on req_wdata is used. Writes of any other length change nothing.
- R8: A read returns rsp_valid high in the next cycle. Offsets other than 0x00 and 0x10 read as 0. Length 1 returns bits 7:0, length 2 returns bits 15:0, lengths 4 and 8 return all 32 bits, and any other length returns 0.
- R9: Reset (synchronous, active high) sets every entry to mask = 1 with all other bits 0, and clears the select register and the ID.
- R10: In the cycle after a low-half write that flips an entry's mask, mchg_valid_o is high for exactly one cycle, with mchg_pin_o = the entry index and mchg_mask_o = the new mask. A write that leaves the mask unchanged gives no event.
- R11: In the cycle after any accepted write to an entry, entry_wr_o pulses for that entry. rirr_clr_o pulses for that entry only if the low half was written.
- R12: route_table_o bits [p*64 +: 64] carry entry p, and they show a write in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 8 | Low byte of the access address |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 32 | Write data (low word of the access) |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| rirr_set_i | input | NUM_PINS | Per-pin set of the remote-IRR flag from delivery logic |
| route_table_o | output | NUM_PINS*64 | All routing entries, entry p at [p*64 +: 64] |
| rirr_clr_o | output | NUM_PINS | Per-pin remote-IRR clear strobe |
| entry_wr_o | output | NUM_PINS | Per-pin entry write pulse |
| mchg_valid_o | output | 1 | Mask-change event |
| mchg_pin_o | output | PIN_W | Pin index of the mask-change event |
| mchg_mask_o | output | 1 | New mask value of the mask-change event |

## Verification
The bench builds the block with its defaults: 24 pins and version code 0x11. With these values the version word reads 0x00170011, and select 0x3F reaches the high half of the last entry. Select 0x40 is the first value past the table, so the R6 boundary sits on both sides of a real edge. Entry 5 is used for the remote-IRR and mask-event corner cases, including a set and a low-half write that land in the same cycle.

// File: rtl/irrf_pkg.sv
package irrf_pkg;

    // Bus offsets of the two directly addressed locations
    localparam logic [7:0]  OFF_SELECT   = 8'h00;
    localparam logic [7:0]  OFF_WINDOW   = 8'h10;

    // Select values reaching the fixed registers
    localparam logic [31:0] SEL_ID       = 32'h0;
    localparam logic [31:0] SEL_VER      = 32'h1;
    localparam logic [31:0] SEL_ARB      = 32'h2;
    localparam logic [31:0] SEL_TAB_BASE = 32'h10;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_ID,
        WK_VER,
        WK_ARB,
        WK_TAB
    } win_kind_e;

    typedef struct packed {
        win_kind_e  kind;
        logic [7:0] idx;
        logic       hi;
    } win_dec_t;

    // Routing entry, MSB first
    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsvd;
        logic        mask;
        logic        trig;
        logic        rirr;
        logic        pol;
        logic        dstat;
        logic        dmode;
        logic [2:0]  dlv;
        logic [7:0]  vec;
    } route_entry_t;

    localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;
    localparam int          MASK_BIT  = 16;

    function automatic logic write_len_ok(input logic [3:0] len);
        return (len == 4'd4) || (len == 4'd8);
    endfunction

    function automatic logic [31:0] size_read(input logic [31:0] v, input logic [3:0] len);
        logic [31:0] r;
        case (len)
            4'd1:       r = {24'h0, v[7:0]};
            4'd2:       r = {16'h0, v[15:0]};
            4'd4, 4'd8: r = v;
            default:    r = 32'h0;
        endcase
        return r;
    endfunction

    function automatic win_dec_t decode_sel(input logic [31:0] sel, input int unsigned pins);
        win_dec_t    d;
        logic [31:0] t;
        d.kind = WK_NONE;
        d.idx  = 8'h0;
        d.hi   = sel[0];
        t      = (sel - SEL_TAB_BASE) >> 1;
        if (sel == SEL_ID)                           d.kind = WK_ID;
        else if (sel == SEL_VER)                     d.kind = WK_VER;
        else if (sel == SEL_ARB)                     d.kind = WK_ARB;
        else if (sel >= SEL_TAB_BASE && t < pins) begin
            d.kind = WK_TAB;
            d.idx  = t[7:0];
        end
        return d;
    endfunction

endpackage

// File: rtl/irrf_route_entry.sv
module irrf_route_entry
    import irrf_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [31:0]  wdata,
    input  logic         rirr_set,
    output route_entry_t entry_o,
    output logic         rirr_clr_o,
    output logic         wr_pulse_o,
    output logic         mask_chg_o
);

    route_entry_t q;
    logic [63:0]  nxt;

    always_comb begin
        nxt = q;
        if (rirr_set)
            nxt[14] = 1'b1;
        if (wr_hi)
            nxt[63:32] = wdata;
        if (wr_lo) begin
            nxt[31:0] = wdata;
            nxt[14]   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q          <= route_entry_t'(ENTRY_RST);
            rirr_clr_o <= 1'b0;
            wr_pulse_o <= 1'b0;
            mask_chg_o <= 1'b0;
        end else begin
            q          <= route_entry_t'(nxt);
            rirr_clr_o <= wr_lo;
            wr_pulse_o <= wr_lo | wr_hi;
            mask_chg_o <= wr_lo && (wdata[MASK_BIT] != q.mask);
        end
    end

    assign entry_o = q;

    // R5: a low-half write leaves remote-IRR clear
    a_r5_lo_clears_rirr: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> !q.rirr);

    // R5: a high-half write alone keeps remote-IRR
    a_r5_hi_keeps_rirr: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && !wr_lo && !rirr_set) |=> (q.rirr == $past(q.rirr)));

    // R9: reset leaves the entry masked
    a_r9_reset_masked: assert property (@(posedge clk)
        rst |=> q.mask);

    // R10: an event only accompanies a real flip of the mask
    a_r10_event_flip: assert property (@(posedge clk) disable iff (rst)
        mask_chg_o |-> (q.mask != $past(q.mask)));

endmodule

// File: rtl/irrf_read_mux.sv
module irrf_read_mux
    import irrf_pkg::*;
#(
    parameter int         NUM_PINS     = 24,
    parameter logic [7:0] VERSION_CODE = 8'h11
) (
    input  logic [7:0]             off,
    input  logic [3:0]             len,
    input  logic [31:0]            sel,
    input  logic [3:0]             id,
    input  win_dec_t               dec,
    input  logic [NUM_PINS*64-1:0] table_i,
    output logic [31:0]            rdata_o
);

    localparam logic [7:0] LAST_PIN = 8'(NUM_PINS - 1);

    logic [31:0] win;
    logic [31:0] raw;

    always_comb begin
        win = 32'h0;
        case (dec.kind)
            WK_VER:        win = {8'h0, LAST_PIN, 8'h0, VERSION_CODE};
            WK_ID, WK_ARB: win = {4'h0, id, 24'h0};
            WK_TAB: begin
                for (int p = 0; p < NUM_PINS; p++) begin
                    if (dec.idx == 8'(p))
                        win = dec.hi ? table_i[p*64+32 +: 32] : table_i[p*64 +: 32];
                end
            end
            default:       win = 32'h0;
        endcase
    end

    always_comb begin
        if (off == OFF_SELECT)      raw = sel;
        else if (off == OFF_WINDOW) raw = win;
        else                        raw = 32'h0;
        rdata_o = size_read(raw, len);
    end

endmodule

// File: rtl/irrf_mask_event.sv
module irrf_mask_event #(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = 5
) (
    input  logic [NUM_PINS-1:0] chg_i,
    input  logic [NUM_PINS-1:0] mask_i,
    output logic                valid_o,
    output logic [PIN_W-1:0]    pin_o,
    output logic                mask_o
);

    always_comb begin
        valid_o = |chg_i;
        pin_o   = '0;
        mask_o  = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (chg_i[p]) begin
                pin_o  = PIN_W'(p);
                mask_o = mask_i[p];
            end
        end
    end

endmodule

// File: rtl/intr_route_regfile.sv
module intr_route_regfile
    import irrf_pkg::*;
#(
    parameter int         NUM_PINS     = 24,
    parameter logic [7:0] VERSION_CODE = 8'h11,
    localparam int        PIN_W        = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [7:0]             req_off,
    input  logic [3:0]             req_len,
    input  logic [31:0]            req_wdata,
    output logic                   rsp_valid,
    output logic [31:0]            rsp_rdata,
    input  logic [NUM_PINS-1:0]    rirr_set_i,
    output logic [NUM_PINS*64-1:0] route_table_o,
    output logic [NUM_PINS-1:0]    rirr_clr_o,
    output logic [NUM_PINS-1:0]    entry_wr_o,
    output logic                   mchg_valid_o,
    output logic [PIN_W-1:0]       mchg_pin_o,
    output logic                   mchg_mask_o
);

    logic [31:0]   sel_q;
    logic [3:0]    id_q;
    win_dec_t      dec;
    logic          wr_ok;
    logic          sel_wr;
    logic          win_wr;
    logic          tab_wr;
    logic [31:0]   rd_val;
    logic [NUM_PINS-1:0] wr_lo_v;
    logic [NUM_PINS-1:0] wr_hi_v;
    logic [NUM_PINS-1:0] chg_v;
    logic [NUM_PINS-1:0] mask_v;
    logic [NUM_PINS*64-1:0] table_w;

    assign dec    = decode_sel(sel_q, NUM_PINS);
    assign wr_ok  = req_valid && req_write && write_len_ok(req_len);
    assign sel_wr = wr_ok && (req_off == OFF_SELECT);
    assign win_wr = wr_ok && (req_off == OFF_WINDOW);
    assign tab_wr = win_wr && (dec.kind == WK_TAB);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= 32'h0;
            id_q      <= 4'h0;
            rsp_valid <= 1'b0;
            rsp_rdata <= 32'h0;
        end else begin
            if (sel_wr)
                sel_q <= req_wdata;
            if (win_wr && dec.kind == WK_ID)
                id_q <= req_wdata[27:24];
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write)
                rsp_rdata <= rd_val;
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_entry
        route_entry_t ent;

        assign wr_lo_v[p] = tab_wr && (dec.idx == 8'(p)) && !dec.hi;
        assign wr_hi_v[p] = tab_wr && (dec.idx == 8'(p)) &&  dec.hi;

        irrf_route_entry u_entry (
            .clk        (clk),
            .rst        (rst),
            .wr_lo      (wr_lo_v[p]),
            .wr_hi      (wr_hi_v[p]),
            .wdata      (req_wdata),
            .rirr_set   (rirr_set_i[p]),
            .entry_o    (ent),
            .rirr_clr_o (rirr_clr_o[p]),
            .wr_pulse_o (entry_wr_o[p]),
            .mask_chg_o (chg_v[p])
        );

        assign table_w[p*64 +: 64] = ent;
        assign mask_v[p]           = ent.mask;
    end

    assign route_table_o = table_w;

    irrf_read_mux #(
        .NUM_PINS     (NUM_PINS),
        .VERSION_CODE (VERSION_CODE)
    ) u_rd (
        .off     (req_off),
        .len     (req_len),
        .sel     (sel_q),
        .id      (id_q),
        .dec     (dec),
        .table_i (table_w),
        .rdata_o (rd_val)
    );

    irrf_mask_event #(
        .NUM_PINS (NUM_PINS),
        .PIN_W    (PIN_W)
    ) u_evt (
        .chg_i   (chg_v),
        .mask_i  (mask_v),
        .valid_o (mchg_valid_o),
        .pin_o   (mchg_pin_o),
        .mask_o  (mchg_mask_o)
    );

    // R10: at most one entry reports a mask change per cycle
    a_r10_single_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chg_v));

    // R7: a write of an unsupported length touches nothing
    a_r7_short_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !(req_len == 4'd4 || req_len == 4'd8))
        |=> ($stable(sel_q) && $stable(id_q) && entry_wr_o == '0));

    // R8: a response only follows a read request
    a_r8_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));

    // R11: a remote-IRR clear always comes with an entry write pulse
    a_r11_clr_implies_wr: assert property (@(posedge clk) disable iff (rst)
        (rirr_clr_o & ~entry_wr_o) == '0);

endmodule

// File: tb/tb_intr_route_regfile.sv
`timescale 1ns/1ps
module tb_intr_route_regfile;

    localparam int NP    = 24;
    localparam int PW    = 5;
    localparam int NVEC  = 41;

    typedef struct packed {
        logic        wr;
        logic [7:0]  off;
        logic [3:0]  len;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'h00, 4'd4, 32'h0000_0001, 32'h0, 8'd2},         // select version
        '{1'b0, 8'h10, 4'd4, 32'h0, 32'h0017_0011, 8'd2},         // R2 version word
        '{1'b1, 8'h10, 4'd4, 32'hFFFF_FFFF, 32'h0, 8'd2},
        '{1'b0, 8'h10, 4'd4, 32'h0, 32'h0017_0011, 8'd2},         // R2 write ignored
        '{1'b1, 8'h00, 4'd4, 32'h0000_0000, 32'h0, 8'd3},
        '{1'b1, 8'h10, 4'd4, 32'h0A00_0000, 32'h0, 8'd3},
        '{1'b0, 8'h10, 4'd4, 32'h0, 32'h0A00_0000, 8'd3},         // R3 ID
        '{1'b1, 8'h00, 4'd4, 32'h0000_0002, 32'h0, 8'd3},
        '{1'b1, 8'h10, 4'd4, 32'h0500_0000, 32'h0, 8'd3},
        '{1'b0, 8'h10, 4'd4, 32'h0, 32'h0A00_0000, 8'd3},         // R3 arb mirror
        '{1'b0, 8'h00, 4'd4, 32'h0, 32'h0000_0002, 8'd1},         // R1 select readback
        '{1'b1, 8'h00, 4'd4, 32'h0000_0013, 32'h0, 8'd4},
        '{1'b1, 8'h10, 4'd4, 32'hC300_0000, 32'h0, 8'd4},
        '{1'b1, 8'h00, 4'd4, 32'h0000_0012, 32'h0, 8'd4},
        '{1'b1, 8'h10, 4'd8, 32'h0000_8031, 32'h0, 8'd7},         // 8-byte write
        '{1'b0, 8'h10, 4'd4, 32'h0, 32'h0000_8031, 8'd7},         // R7
        '{1'b1, 8'h00, 4'd4, 32'h0000_0013, 32'h0, 8'd4},
        '{1'b0, 8'h10, 4'd4, 32'h0, 32'hC300_0000, 8'd4},         // R4 high half
        '{1'b1, 8'h00, 4'd4, 32'h0000_003F, 32'h0, 8'd4},
        '{1'b1, 8'h10, 4'd4, 32'h1111_1111, 32'h0, 8'd4},
        '{1'b0, 8'h10, 4'd4, 32'h0, 32'h1111_1111, 8'd4},         // R4 last pin
        '{1'b1, 8'h00, 4'd4, 32'h0000_0040, 32'h0, 8'd6},
        '{1'b1, 8'h10, 4'd4, 32'h2222_2222, 32'h0, 8'd6},
        '{1'b0, 8'h10, 4'd4, 32'h0, 32'h0, 8'd6},                 // R6 past table
        '{1'b1, 8'h00, 4'd4, 32'h0000_0005, 32'h0, 8'd6},
        '{1'b1, 8'h10, 4'd4, 32'h3333_3333, 32'h0, 8'd6},
        '{1'b0, 8'h10, 4'd4, 32'h0, 32'h0, 8'd6},                 // R6 gap select
        '{1'b1, 8'h00, 4'd4, 32'h0000_0012, 32'h0, 8'd7},
        '{1'b1, 8'h10, 4'd2, 32'h0000_0000, 32'h0, 8'd7},
        '{1'b1, 8'h10, 4'd1, 32'h0000_0000, 32'h0, 8'd7},
        '{1'b1, 8'h10, 4'd3, 32'h0000_0000, 32'h0, 8'd7},
        '{1'b0, 8'h10, 4'd4, 32'h0, 32'h0000_8031, 8'd7},         // R7 short writes dropped
        '{1'b0, 8'hF8, 4'd4, 32'h0, 32'h0, 8'd8},                 // R8 other offset
        '{1'b0, 8'h20, 4'd4, 32'h0, 32'h0, 8'd8},
        '{1'b0, 8'h00, 4'd1, 32'h0, 32'h0000_0012, 8'd8},
        '{1'b0, 8'h10, 4'd1, 32'h0, 32'h0000_0031, 8'd8},
        '{1'b0, 8'h10, 4'd2, 32'h0, 32'h0000_8031, 8'd8},
        '{1'b0, 8'h10, 4'd3, 32'h0, 32'h0, 8'd8},
        '{1'b0, 8'h10, 4'd8, 32'h0, 32'h0000_8031, 8'd8},
        '{1'b1, 8'h00, 4'd2, 32'h0000_0077, 32'h0, 8'd7},
        '{1'b0, 8'h00, 4'd4, 32'h0, 32'h0000_0012, 8'd7}          // R7 short select write
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [7:0]        req_off = 8'h0;
    logic [3:0]        req_len = 4'd0;
    logic [31:0]       req_wdata = 32'h0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic [NP-1:0]     rirr_set = '0;
    logic [NP*64-1:0]  route_table;
    logic [NP-1:0]     rirr_clr;
    logic [NP-1:0]     entry_wr;
    logic              mchg_valid;
    logic [PW-1:0]     mchg_pin;
    logic              mchg_mask;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    intr_route_regfile #(.NUM_PINS(NP), .VERSION_CODE(8'h11)) dut (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_off       (req_off),
        .req_len       (req_len),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .rirr_set_i    (rirr_set),
        .route_table_o (route_table),
        .rirr_clr_o    (rirr_clr),
        .entry_wr_o    (entry_wr),
        .mchg_valid_o  (mchg_valid),
        .mchg_pin_o    (mchg_pin),
        .mchg_mask_o   (mchg_mask)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] off, input logic [3:0] len, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_off = off; req_len = len; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] off, input logic [3:0] len, output logic [31:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_off = off; req_len = len;
        @(posedge clk); #1;
        req_valid = 1'b0;
        d = rsp_rdata;
        v = rsp_valid;
    endtask

    function automatic logic [63:0] ent(input int p);
        return route_table[p*64 +: 64];
    endfunction

    initial begin
        logic [31:0] rd;
        logic        rv;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R9: reset state
        begin
            bit all_ok = 1'b1;
            for (int p = 0; p < NP; p++)
                if (ent(p) != 64'h1_0000) all_ok = 1'b0;
            chk(all_ok, "R9 entries masked", ent(0), 64'h1_0000);
        end
        chk(mchg_valid == 1'b0 && rirr_clr == '0, "R9 no events", {63'h0, mchg_valid}, 64'h0);
        do_read(8'h00, 4'd4, rd, rv);
        chk(rd == 32'h0, "R9 select cleared", rd, 32'h0);
        do_read(8'h10, 4'd4, rd, rv);
        chk(rd == 32'h0, "R9 id cleared", rd, 32'h0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].wr) begin
                do_write(VECS[i].off, VECS[i].len, VECS[i].data);
            end else begin
                do_read(VECS[i].off, VECS[i].len, rd, rv);
                chk(rv == 1'b1, $sformatf("R8 rsp_valid vec %0d", i), {63'h0, rv}, 64'h1);
                chk(rd == VECS[i].exp, $sformatf("R%0d vec %0d", VECS[i].req, i), rd, VECS[i].exp);
            end
        end

        // R12 / R6: table contents at the ports
        chk(ent(1) == 64'hC300_0000_0000_8031, "R12 entry 1", ent(1), 64'hC300_0000_0000_8031);
        chk(ent(23) == 64'h1111_1111_0001_0000, "R12 entry 23", ent(23), 64'h1111_1111_0001_0000);
        chk(ent(0) == 64'h1_0000, "R6 entry 0 untouched", ent(0), 64'h1_0000);

        // R5: remote-IRR set, kept by high write, cleared by low write
        do_write(8'h00, 4'd4, 32'h1B);
        @(negedge clk) rirr_set[5] = 1'b1;
        @(posedge clk); #1 rirr_set[5] = 1'b0;
        chk(ent(5)[14] == 1'b1, "R5 set", {63'h0, ent(5)[14]}, 64'h1);
        do_write(8'h10, 4'd4, 32'h0700_0000);
        chk(ent(5)[14] == 1'b1, "R5 high keeps", {63'h0, ent(5)[14]}, 64'h1);
        chk(entry_wr[5] == 1'b1 && rirr_clr[5] == 1'b0, "R11 high pulse", {62'h0, entry_wr[5], rirr_clr[5]}, 64'h2);
        chk(mchg_valid == 1'b0, "R10 no event on high", {63'h0, mchg_valid}, 64'h0);

        do_write(8'h00, 4'd4, 32'h1A);
        do_write(8'h10, 4'd4, 32'h0000_C022);
        chk(ent(5) == 64'h0700_0000_0000_8022, "R5 low clears / R4 layout", ent(5), 64'h0700_0000_0000_8022);
        chk(entry_wr[5] == 1'b1 && rirr_clr[5] == 1'b1, "R11 low pulse", {62'h0, entry_wr[5], rirr_clr[5]}, 64'h3);
        chk(mchg_valid && mchg_pin == 5'd5 && !mchg_mask, "R10 unmask event",
            {56'h0, mchg_valid, mchg_pin, mchg_mask}, {56'h0, 1'b1, 5'd5, 1'b0});
        @(posedge clk); #1;
        chk(mchg_valid == 1'b0 && rirr_clr == '0, "R10 one cycle", {63'h0, mchg_valid}, 64'h0);

        do_write(8'h10, 4'd4, 32'h0001_8022);
        chk(mchg_valid && mchg_pin == 5'd5 && mchg_mask, "R10 mask event",
            {56'h0, mchg_valid, mchg_pin, mchg_mask}, {56'h0, 1'b1, 5'd5, 1'b1});
        do_write(8'h10, 4'd4, 32'h0001_8023);
        chk(mchg_valid == 1'b0, "R10 unchanged mask", {63'h0, mchg_valid}, 64'h0);

        // R5: set and low write in the same cycle, clear wins
        @(negedge clk) rirr_set[5] = 1'b1;
        do_write(8'h10, 4'd4, 32'h0001_8023);
        rirr_set[5] = 1'b0;
        chk(ent(5)[14] == 1'b0, "R5 clear beats set", {63'h0, ent(5)[14]}, 64'h0);

        // R9: reset mid-run
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk) rst = 1'b0;
        chk(ent(5) == 64'h1_0000, "R9 entry 5 after reset", ent(5), 64'h1_0000);
        do_read(8'h00, 4'd4, rd, rv);
        chk(rd == 32'h0, "R9 select after reset", rd, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule